// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns a serial input line into parallel characters of 5 to 8 data bits, with an optional even or odd parity bit and one stop bit. Bit timing comes from a receive-clock tick (`samp_tick`, one clock-wide pulse per receive-clock edge). The tick rate is either equal to the bit rate (1x) or 16, 32 or 64 times the bit rate. At the higher factors a falling edge is confirmed as a start bit by a second look half a bit later. Each later bit is sampled at its centre.

A finished character moves from the shift register into a holding register. This raises a ready flag and may pull the active-low interrupt. A read strobe from the CPU side clears the ready flag. Parity, framing and overrun errors are sticky until a status-clear strobe. An all-zero frame whose stop bit is also low is a break. It sets a break flag, a delta-break flag and a change flag. The break ends only after the line has stayed high for half a bit time.

The frame state machine has six states:
- `ST_HUNT` watches for a high-to-low edge. It goes to `ST_CONFIRM`, or straight to `ST_DATA` at 1x.
- `ST_CONFIRM` resamples at half a bit. A low line goes to `ST_DATA`; a high line returns to `ST_HUNT`.
- `ST_DATA` takes the programmed number of bits. It then goes to `ST_PARITY` when parity is on, otherwise to `ST_STOP`.
- `ST_PARITY` takes one bit and goes to `ST_STOP`.
- `ST_STOP` returns to `ST_HUNT` on a high stop bit or a framing error, and enters `ST_BREAK` on an all-zero frame.
- `ST_BREAK` returns to `ST_HUNT` after half a bit time of high line.

Whenever the receiver is not enabled, the machine is forced to `ST_HUNT`.

Top module: `srx_receiver`

## Requirements
- R1: `cfg_len` selects 5 (0), 6 (1), 7 (2) or 8 (3) data bits, received LSB first. The holding-register bits above the programmed length read as 0.
- R2: At factors 16x/32x/64x, a falling edge on `rx_line` is resampled half a bit time (F/2 ticks) later. If the line is high by then, no character is assembled and hunting resumes.
- R3: At 1x (`cfg_factor`=0) there is no resample. The tick after the falling edge samples data bit 0, and each later tick samples the next bit.
- R4: `cfg_factor` encodes 0=1x, 1=16x, 2=32x, 3=64x ticks per bit. Data, parity and stop bits are sampled every F ticks from the confirmed start-bit centre.
- R5: With `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=0 expects an even count of ones and 1 expects an odd count over data plus parity. A mismatch sets `parity_err` with the character.
- R6: A low stop bit in a frame that is not all zeros sets `framing_err`. The character is still delivered.
- R7: A frame with all data bits 0, a 0 parity bit when enabled and a 0 stop bit is a break. It sets `break_on` and `break_delta`, then `change_flag`, and does not deliver a character.
- R8: `break_on` clears only after `rx_line` has been high for F/2 consecutive ticks (1 tick at 1x). The end of a break sets `break_delta` again.
- R9: A transfer to the holding register sets `rx_ready`. `rd_strobe` clears it, and a transfer in the same cycle wins.
- R10: A transfer while `rx_ready` is set, without a read in that cycle, sets `overrun_err`, and the newer character overwrites `rx_data`.
- R11: `parity_err`, `framing_err`, `overrun_err`, `break_delta` and `change_flag` stay set until `status_clr`. `rd_strobe` does not clear them.
- R12: `irq_n` is low exactly when (`rx_ready` and `mask_ready`) or (`change_flag` and `mask_change`).
- R13: The receiver runs only while `rx_enable`=1 and, if `auto_enable`=1, `carrier_n`=0. Otherwise it stays hunting and delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One pulse per receive-clock edge |
| rx_line | input | 1 | Serial data input, idle high |
| rx_enable | input | 1 | Receiver enable command |
| auto_enable | input | 1 | Makes reception also depend on `carrier_n` |
| carrier_n | input | 1 | Active-low modem-control input |
| cfg_factor | input | 2 | Clock factor: 0=1x, 1=16x, 2=32x, 3=64x |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| mask_ready | input | 1 | Lets `rx_ready` drive the interrupt |
| mask_change | input | 1 | Lets `change_flag` drive the interrupt |
| rd_strobe | input | 1 | Holding-register read, clears `rx_ready` |
| status_clr | input | 1 | Clears the sticky error and change flags |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character available |
| parity_err | output | 1 | Sticky parity error |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |
| break_on | output | 1 | Break condition in progress |
| break_delta | output | 1 | Sticky break start/end change |
| change_flag | output | 1 | Sticky data-set change status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check the cycle-level rules on every cycle:
- the ready flag rises only on a transfer and falls after an unmasked read;
- an overrun follows a transfer onto a full holding register;
- error flags hold until cleared;
- a framing error matches a low stop sample;
- a break never delivers a character;
- a disabled receiver sits in `ST_HUNT`.

Only the bench scenarios can show that the sampled bits, lengths and parity values come out correct at each clock factor. The same holds for a short glitch being rejected, for the half-bit idle window that ends a break, and for the enable gating by the modem-control input.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CONFIRM,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } srx_state_e;

    // Ticks per bit for a factor code (0=1x, 1=16x, 2=32x, 3=64x)
    function automatic logic [6:0] ticks_per_bit(input logic [1:0] code);
        logic [6:0] r;
        unique case (code)
            2'd0:    r = 7'd1;
            2'd1:    r = 7'd16;
            2'd2:    r = 7'd32;
            default: r = 7'd64;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx_in,
    input  logic          run,
    input  logic [1:0]    cfg_factor,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    output logic          done,
    output logic [DW-1:0] char_out,
    output logic          perr_out,
    output logic          ferr_out,
    output logic          brk_start,
    output logic          brk_end
);
    localparam int IW = $clog2(DW);

    srx_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] bit_len, half_len;
    logic [IW-1:0] idx, last_idx;
    logic [DW-1:0] sr;
    logic          prev, par_acc, nz_acc, perr_hold;
    logic          one_x, at_pt, brk_done;

    always_comb begin
        bit_len  = CW'(ticks_per_bit(cfg_factor));
        one_x    = (cfg_factor == 2'd0);
        half_len = one_x ? CW'(1) : (bit_len >> 1);
        last_idx = IW'(cfg_len) + IW'(4);
        at_pt    = tick && (cnt == ((state == ST_CONFIRM) ? half_len - CW'(1)
                                                          : bit_len - CW'(1)));
        brk_done = tick && rx_in && (cnt == half_len - CW'(1));
    end

    // Next-state process
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:    if (tick && prev && !rx_in) nxt = one_x ? ST_DATA : ST_CONFIRM;
            ST_CONFIRM: if (at_pt) nxt = rx_in ? ST_HUNT : ST_DATA;
            ST_DATA:    if (at_pt && idx == last_idx) nxt = cfg_par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:  if (at_pt) nxt = ST_STOP;
            ST_STOP:    if (at_pt) nxt = (!rx_in && !nz_acc) ? ST_BREAK : ST_HUNT;
            ST_BREAK:   if (brk_done) nxt = ST_HUNT;
            default:    nxt = ST_HUNT;
        endcase
        if (!run) nxt = ST_HUNT;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // Datapath and output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            idx       <= '0;
            sr        <= '0;
            prev      <= 1'b0;
            par_acc   <= 1'b0;
            nz_acc    <= 1'b0;
            perr_hold <= 1'b0;
            done      <= 1'b0;
            char_out  <= '0;
            perr_out  <= 1'b0;
            ferr_out  <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            done      <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (!run) begin
                cnt  <= '0;
                prev <= 1'b0;
            end else if (tick) begin
                unique case (state)
                    ST_HUNT: begin
                        prev      <= rx_in;
                        cnt       <= '0;
                        idx       <= '0;
                        sr        <= '0;
                        par_acc   <= 1'b0;
                        nz_acc    <= 1'b0;
                        perr_hold <= 1'b0;
                    end
                    ST_CONFIRM: cnt <= at_pt ? '0 : cnt + CW'(1);
                    ST_DATA: begin
                        if (at_pt) begin
                            sr[idx] <= rx_in;
                            par_acc <= par_acc ^ rx_in;
                            nz_acc  <= nz_acc | rx_in;
                            idx     <= idx + IW'(1);
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_PARITY: begin
                        if (at_pt) begin
                            perr_hold <= par_acc ^ rx_in ^ cfg_par_odd;
                            nz_acc    <= nz_acc | rx_in;
                            cnt       <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (at_pt) begin
                            cnt <= '0;
                            if (rx_in) begin
                                done     <= 1'b1;
                                char_out <= sr;
                                perr_out <= perr_hold;
                                ferr_out <= 1'b0;
                                prev     <= 1'b1;
                            end else if (!nz_acc) begin
                                brk_start <= 1'b1;
                            end else begin
                                done     <= 1'b1;
                                char_out <= sr;
                                perr_out <= perr_hold;
                                ferr_out <= 1'b1;
                                prev     <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_BREAK: begin
                        if (brk_done) begin
                            brk_end <= 1'b1;
                            prev    <= 1'b1;
                            cnt     <= '0;
                        end else if (rx_in) begin
                            cnt <= cnt + CW'(1);
                        end else begin
                            cnt <= '0;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    assert_len_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_len == 2'd0) |-> ((char_out >> 5) == '0));
    assert_onex_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && one_x && state == ST_HUNT) |=> (state != ST_CONFIRM));
    assert_ferr_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ferr_out) |-> !$past(rx_in));
    assert_brk_nochar_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && brk_start));
    assert_idle_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_HUNT));

endmodule

// File: rtl/srx_status.sv
module srx_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_perr,
    input  logic          ld_ferr,
    input  logic          brk_start,
    input  logic          brk_end,
    input  logic          rd_stb,
    input  logic          clr_stb,
    input  logic          mask_rdy,
    input  logic          mask_chg,
    output logic [DW-1:0] hold,
    output logic          ready,
    output logic          perr,
    output logic          ferr,
    output logic          ovr,
    output logic          brk,
    output logic          dbrk,
    output logic          dsc,
    output logic          irq_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
            brk   <= 1'b0;
            dbrk  <= 1'b0;
            dsc   <= 1'b0;
        end else begin
            if (ld) begin
                hold  <= ld_data;
                ready <= 1'b1;
            end else if (rd_stb) begin
                ready <= 1'b0;
            end

            if (ld && ready && !rd_stb) ovr <= 1'b1;
            else if (clr_stb)           ovr <= 1'b0;

            if (ld && ld_perr) perr <= 1'b1;
            else if (clr_stb)  perr <= 1'b0;

            if (ld && ld_ferr) ferr <= 1'b1;
            else if (clr_stb)  ferr <= 1'b0;

            if (brk_start)    brk <= 1'b1;
            else if (brk_end) brk <= 1'b0;

            if (brk_start || brk_end) dbrk <= 1'b1;
            else if (clr_stb)         dbrk <= 1'b0;

            if (dbrk && !clr_stb) dsc <= 1'b1;
            else if (clr_stb)     dsc <= 1'b0;
        end
    end

    always_comb irq_n = !((ready && mask_rdy) || (dsc && mask_chg));

    assert_ready_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(ld));
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !ld) |=> !ready);
    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && ready && !rd_stb) |=> ovr);
    assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !clr_stb) |=> perr);
    assert_chg_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc && mask_chg) |-> !irq_n);

endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
    import srx_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_tick,
    input  logic          rx_line,
    input  logic          rx_enable,
    input  logic          auto_enable,
    input  logic          carrier_n,
    input  logic [1:0]    cfg_factor,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          mask_ready,
    input  logic          mask_change,
    input  logic          rd_strobe,
    input  logic          status_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          parity_err,
    output logic          framing_err,
    output logic          overrun_err,
    output logic          break_on,
    output logic          break_delta,
    output logic          change_flag,
    output logic          irq_n
);
    logic          run;
    logic          f_done, f_perr, f_ferr, f_bstart, f_bend;
    logic [DW-1:0] f_char;

    always_comb run = rx_enable && (!auto_enable || !carrier_n);

    srx_frame_fsm #(.DW(DW), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (samp_tick),
        .rx_in      (rx_line),
        .run        (run),
        .cfg_factor (cfg_factor),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .done       (f_done),
        .char_out   (f_char),
        .perr_out   (f_perr),
        .ferr_out   (f_ferr),
        .brk_start  (f_bstart),
        .brk_end    (f_bend)
    );

    srx_status #(.DW(DW)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (f_done),
        .ld_data  (f_char),
        .ld_perr  (f_perr),
        .ld_ferr  (f_ferr),
        .brk_start(f_bstart),
        .brk_end  (f_bend),
        .rd_stb   (rd_strobe),
        .clr_stb  (status_clr),
        .mask_rdy (mask_ready),
        .mask_chg (mask_change),
        .hold     (rx_data),
        .ready    (rx_ready),
        .perr     (parity_err),
        .ferr     (framing_err),
        .ovr      (overrun_err),
        .brk      (break_on),
        .dbrk     (break_delta),
        .dsc      (change_flag),
        .irq_n    (irq_n)
    );

endmodule

// File: tb/srx_receiver_tb.sv
module srx_receiver_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_tick = 1'b1;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b1, auto_enable = 1'b0, carrier_n = 1'b1;
    logic [1:0] cfg_factor = 2'd1, cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       mask_ready = 1'b0, mask_change = 1'b0;
    logic       rd_strobe = 1'b0, status_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, parity_err, framing_err, overrun_err;
    logic       break_on, break_delta, change_flag, irq_n;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    srx_receiver u_dut (.*);

    typedef struct packed {
        logic [1:0] fac;
        logic [1:0] len;
        logic       pe;
        logic       odd;
        logic       badp;
        logic       stopv;
        logic [7:0] din;
        logic [7:0] dexp;
        logic       pexp;
        logic       fexp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0, 1'b0},
        '{2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h5A, 1'b0, 1'b0},
        '{2'd3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, 8'h3C, 1'b0, 1'b0},
        '{2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h1F, 1'b0, 1'b0},
        '{2'd1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 8'h81, 1'b1, 1'b0},
        '{2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0},
        '{2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h42, 8'h42, 1'b0, 1'b1},
        '{2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC3, 8'hC3, 1'b0, 1'b0},
        '{2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h15, 8'h15, 1'b1, 1'b0}
    };

    function automatic int tpb(input logic [1:0] f);
        return (f == 2'd0) ? 1 : (f == 2'd1) ? 16 : (f == 2'd2) ? 32 : 64;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] fac, input logic [1:0] len, input logic pe,
                        input logic odd, input logic badp, input logic stopv,
                        input logic [7:0] din);
        int   f = tpb(fac);
        int   nb = int'(len) + 5;
        logic p = 1'b0;
        hold_bit(1'b1, f);
        hold_bit(1'b0, f);
        for (int i = 0; i < nb; i++) begin
            p ^= din[i];
            hold_bit(din[i], f);
        end
        if (pe) hold_bit(p ^ odd ^ badp, f);
        hold_bit(stopv, f);
        hold_bit(1'b1, 2 * f);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        status_clr = 1'b1; @(negedge clk); status_clr = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R9, R12)
        check("R9 reset ready", rx_ready, 0);
        check("R12 reset irq_n", irq_n, 1);
        check("R7 reset break", break_on, 0);

        // Vector table: R1 R3 R4 R5 R6 R11
        foreach (VECS[k]) begin
            cfg_factor  = VECS[k].fac;
            cfg_len     = VECS[k].len;
            cfg_par_en  = VECS[k].pe;
            cfg_par_odd = VECS[k].odd;
            send(VECS[k].fac, VECS[k].len, VECS[k].pe, VECS[k].odd, VECS[k].badp,
                 VECS[k].stopv, VECS[k].din);
            check($sformatf("R4 R1 vec%0d data", k), rx_data, VECS[k].dexp);
            check($sformatf("R9 vec%0d ready", k), rx_ready, 1);
            check($sformatf("R5 vec%0d parity", k), parity_err, VECS[k].pexp);
            check($sformatf("R6 vec%0d framing", k), framing_err, VECS[k].fexp);
            pulse_rd();
            check($sformatf("R9 vec%0d ready cleared", k), rx_ready, 0);
            check($sformatf("R11 vec%0d perr after read", k), parity_err, VECS[k].pexp);
            pulse_clr();
            check($sformatf("R11 vec%0d perr cleared", k), parity_err, 0);
        end

        // Glitch rejection (R2)
        cfg_factor = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0;
        hold_bit(1'b1, 16);
        hold_bit(1'b0, 4);
        hold_bit(1'b1, 40);
        check("R2 glitch no char", rx_ready, 0);
        send(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33);
        check("R2 after glitch data", rx_data, 8'h33);
        pulse_rd();

        // Overrun (R10) and clear (R11)
        send(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11);
        check("R10 no overrun yet", overrun_err, 0);
        send(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22);
        check("R10 overrun set", overrun_err, 1);
        check("R10 newer data", rx_data, 8'h22);

        // Interrupt masking (R12)
        mask_ready = 1'b1; @(negedge clk);
        check("R12 irq with ready", irq_n, 0);
        mask_ready = 1'b0; @(negedge clk);
        check("R12 irq masked", irq_n, 1);
        mask_ready = 1'b1;
        pulse_rd();
        check("R12 irq after read", irq_n, 1);
        check("R11 overrun survives read", overrun_err, 1);
        pulse_clr();
        check("R11 overrun cleared", overrun_err, 0);

        // Enable gating (R13)
        rx_enable = 1'b0;
        send(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5E);
        check("R13 disabled no char", rx_ready, 0);
        rx_enable = 1'b1; auto_enable = 1'b1; carrier_n = 1'b1;
        send(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5E);
        check("R13 carrier high no char", rx_ready, 0);
        carrier_n = 1'b0;
        send(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5E);
        check("R13 carrier low char", rx_data, 8'h5E);
        pulse_rd();
        auto_enable = 1'b0;

        // Break (R7, R8)
        mask_change = 1'b1;
        hold_bit(1'b1, 16);
        hold_bit(1'b0, 16 * 13);
        check("R7 break no char", rx_ready, 0);
        check("R7 break on", break_on, 1);
        check("R7 delta set", break_delta, 1);
        check("R7 change flag", change_flag, 1);
        check("R7 irq from change", irq_n, 0);
        check("R6 break not framing", framing_err, 0);
        pulse_clr();
        check("R11 delta cleared", break_delta, 0);
        hold_bit(1'b1, 4);
        check("R8 break held at 4 ticks", break_on, 1);
        hold_bit(1'b1, 6);
        check("R8 break ended", break_on, 0);
        check("R8 delta on end", break_delta, 1);
        pulse_clr();
        mask_change = 1'b0;

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule